// File: doc/BRIEF.md
# DMA Command-Queue Control Register Block

This block is the software-facing register set of a DMA command queue. A processor reaches it over a simple 32-bit register bus inside a 4 KiB window. The block holds the queue's base, end, write and read pointers, an interrupt enable word and an interrupt status word. It drives one level-sensitive interrupt line.

Moving the write pointer models the queued transfers finishing at once. The read pointer takes the new write-pointer value, and both completion flags (upstream and downstream) are set in the status word. A special key written to the read-pointer slot arms a one-shot that swallows the next completion. With the key armed, the next write-pointer update still moves both pointers, but it leaves the status and the interrupt alone.

Each bus request lasts one cycle: valid, write, address and write data. Read data comes back registered on the next cycle. The low two address bits are ignored, and all accesses are full 32-bit words.

Top module: `dmaq_csr`

## Requirements
- R1: After reset the status word (offset 0x24) reads 0xF8000000, every other word in the register range reads 0, the one-shot is disarmed and `irq_out` is low.
- R2: A write to the end pointer (offset 0x14) stores only data bits [17:0]; bits [31:18] read back as 0.
- R3: A write to the write pointer (offset 0x18) stores data bits [17:0] only, and the same masked value also appears in the read pointer (offset 0x1C).
- R4: Writing the key 0xEE882266 to offset 0x1C arms the one-shot and leaves the read pointer unchanged. Any other value written there has no effect at all.
- R5: A write-pointer write with the one-shot disarmed sets status bits 4 and 5. With it armed, the write disarms it and leaves the status word and `irq_out` unchanged.
- R6: `irq_out` goes high on the cycle after a status-setting write-pointer write if enable bit 4 or bit 5 (offset 0x20) is 1. If both are 0, `irq_out` stays as it was.
- R7: A write to the enable word stores the data ANDed with 0xBFEFF07F.
- R8: A write to the status word with data bit 4 or bit 5 set clears both status bits 4 and 5 and drops `irq_out` on the next cycle. Other data bits never change the status word.
- R9: `irq_out` is a held level. Only an R8 clear or reset lowers it, and writing the enable word neither raises nor lowers it.
- R10: Any other word below offset 0x80 is plain 32-bit storage, including the base address at 0x10. Reads at or above 0x80 return 0, and writes there change nothing.
- R11: For a read request, `bus_rdata` shows the addressed word on the cycle after the request and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Completion interrupt level |

## Verification
The bench first arms the one-shot with the key. It then checks that exactly one write-pointer update is swallowed and that the next one raises the interrupt. A design that did not disarm the one-shot would miss every later completion, and one that changed the read pointer on the key write would report a wrong read-pointer value. Other cases target wrong masking of the end, write and enable words, and a status write without bits 4 or 5, which must not clear anything. They also target enable-word writes, which must not move a pending interrupt, and aliasing of out-of-range offsets back into the register file. Random mixed traffic, including the key and the clear patterns, is compared against a bench-side model on every read and every cycle of the interrupt.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int unsigned WORD_W   = 32;
  // Word indices whose behaviour is special; offsets = index * 4
  localparam int unsigned IDX_END  = 5;   // 0x14
  localparam int unsigned IDX_WP   = 6;   // 0x18
  localparam int unsigned IDX_RP   = 7;   // 0x1C
  localparam int unsigned IDX_EN   = 8;   // 0x20
  localparam int unsigned IDX_ST   = 9;   // 0x24

  localparam logic [31:0] PTR_KEEP  = 32'h0003_FFFF;
  localparam logic [31:0] EN_KEEP   = 32'hBFEF_F07F;
  localparam logic [31:0] ARM_KEY   = 32'hEE88_2266;
  localparam logic [31:0] ST_INIT   = 32'hF800_0000;
  localparam logic [31:0] CMPL_BITS = 32'h0000_0030;

  typedef struct packed {
    logic end_wr;
    logic wp_wr;
    logic rp_wr;
    logic en_wr;
    logic st_wr;
    logic gen_wr;
    logic rd;
  } strobe_t;

  function automatic logic [31:0] keep_ptr(input logic [31:0] v);
    return v & PTR_KEEP;
  endfunction

  function automatic logic [31:0] keep_en(input logic [31:0] v);
    return v & EN_KEEP;
  endfunction

  function automatic logic touches_cmpl(input logic [31:0] v);
    return |(v & CMPL_BITS);
  endfunction

  function automatic logic is_special(input int unsigned i);
    return (i == IDX_END) || (i == IDX_WP) || (i == IDX_RP) ||
           (i == IDX_EN)  || (i == IDX_ST);
  endfunction
endpackage

// File: rtl/dmaq_decode.sv
module dmaq_decode
  import dmaq_pkg::*;
#(
  parameter int unsigned WORD_AW  = 10,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic               valid,
  input  logic               write,
  input  logic [WORD_AW-1:0] word,
  output strobe_t            stb,
  output logic [IDX_W-1:0]   idx,
  output logic               in_range
);
  logic wr;

  assign in_range = 32'(word) < 32'(NUM_REGS);
  assign idx      = word[IDX_W-1:0];
  assign wr       = valid & write & in_range;

  always_comb begin
    stb        = '0;
    stb.rd     = valid & ~write;
    stb.end_wr = wr && (idx == IDX_W'(IDX_END));
    stb.wp_wr  = wr && (idx == IDX_W'(IDX_WP));
    stb.rp_wr  = wr && (idx == IDX_W'(IDX_RP));
    stb.en_wr  = wr && (idx == IDX_W'(IDX_EN));
    stb.st_wr  = wr && (idx == IDX_W'(IDX_ST));
    stb.gen_wr = wr && !stb.end_wr && !stb.wp_wr && !stb.rp_wr &&
                 !stb.en_wr && !stb.st_wr;
  end
endmodule

// File: rtl/dmaq_qptr.sv
module dmaq_qptr
  import dmaq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        end_wr,
  input  logic        wp_wr,
  input  logic        rp_wr,
  input  logic [31:0] wdata,
  output logic [31:0] end_q,
  output logic [31:0] wp_q,
  output logic [31:0] rp_q,
  output logic        armed_q,
  output logic        cmpl_evt
);
  // a write-pointer move completes the queue unless the one-shot swallows it
  assign cmpl_evt = wp_wr & ~armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      end_q   <= '0;
      wp_q    <= '0;
      rp_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (end_wr) end_q <= keep_ptr(wdata);
      if (wp_wr) begin
        wp_q <= keep_ptr(wdata);
        rp_q <= keep_ptr(wdata);
        if (armed_q) armed_q <= 1'b0;
      end
      if (rp_wr && (wdata == ARM_KEY)) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dmaq_irqst.sv
module dmaq_irqst
  import dmaq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        st_wr,
  input  logic        cmpl_evt,
  input  logic [31:0] wdata,
  output logic [31:0] en_q,
  output logic [31:0] st_q,
  output logic        irq_q,
  output logic        clr_evt
);
  logic en_hit;

  assign clr_evt = st_wr & touches_cmpl(wdata);
  assign en_hit  = touches_cmpl(en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      st_q  <= ST_INIT;
      irq_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= keep_en(wdata);
      if (cmpl_evt) begin
        st_q <= st_q | CMPL_BITS;
        if (en_hit) irq_q <= 1'b1;
      end else if (clr_evt) begin
        st_q  <= st_q & ~CMPL_BITS;
        irq_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmaq_csr.sv
module dmaq_csr
  import dmaq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam int unsigned IDX_W   = $clog2(NUM_REGS);
  localparam int unsigned WORD_AW = ADDR_W - 2;

  strobe_t          stb;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [31:0]      end_q, wp_q, rp_q, en_q, st_q;
  logic             armed_q, cmpl_evt, clr_evt, wp_wr;
  logic [31:0]      gen_q [NUM_REGS];
  logic [31:0]      rmux;

  dmaq_decode #(.WORD_AW(WORD_AW), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .valid(bus_valid), .write(bus_write), .word(bus_addr[ADDR_W-1:2]),
    .stb(stb), .idx(idx), .in_range(in_range)
  );

  assign wp_wr = stb.wp_wr;

  dmaq_qptr u_qptr (
    .clk(clk), .rst_n(rst_n), .end_wr(stb.end_wr), .wp_wr(stb.wp_wr),
    .rp_wr(stb.rp_wr), .wdata(bus_wdata), .end_q(end_q), .wp_q(wp_q),
    .rp_q(rp_q), .armed_q(armed_q), .cmpl_evt(cmpl_evt)
  );

  dmaq_irqst u_irq (
    .clk(clk), .rst_n(rst_n), .en_wr(stb.en_wr), .st_wr(stb.st_wr),
    .cmpl_evt(cmpl_evt), .wdata(bus_wdata), .en_q(en_q), .st_q(st_q),
    .irq_q(irq_out), .clr_evt(clr_evt)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    if (is_special(g)) begin : g_special
      assign gen_q[g] = '0;
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n) gen_q[g] <= '0;
        else if (stb.gen_wr && (idx == IDX_W'(g))) gen_q[g] <= bus_wdata;
      end
    end
  end

  always_comb begin
    if      (idx == IDX_W'(IDX_END)) rmux = end_q;
    else if (idx == IDX_W'(IDX_WP))  rmux = wp_q;
    else if (idx == IDX_W'(IDX_RP))  rmux = rp_q;
    else if (idx == IDX_W'(IDX_EN))  rmux = en_q;
    else if (idx == IDX_W'(IDX_ST))  rmux = st_q;
    else                             rmux = gen_q[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (stb.rd) bus_rdata <= in_range ? rmux : '0;
  end
endmodule

// File: rtl/dmaq_csr_chk.sv
module dmaq_csr_chk
  import dmaq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        cmpl_evt,
  input logic        clr_evt,
  input logic        wp_wr,
  input logic        armed_q,
  input logic [31:0] end_q,
  input logic [31:0] wp_q,
  input logic [31:0] rp_q,
  input logic [31:0] en_q,
  input logic [31:0] st_q
);
  a_r2_end_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    end_q[31:18] == 14'd0);

  a_r3_rp_follows_wp: assert property (@(posedge clk) disable iff (!rst_n)
    wp_wr |=> (rp_q == wp_q) && (wp_q[31:18] == 14'd0));

  a_r5_oneshot_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    wp_wr && armed_q |=> !armed_q && $stable(st_q) && $stable(irq));

  a_r5_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt |=> ((st_q & CMPL_BITS) == CMPL_BITS));

  a_r6_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt && (en_q[4] || en_q[5]) |=> irq);

  a_r6_irq_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !cmpl_evt |=> !irq);

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !irq && ((st_q & CMPL_BITS) == 32'd0));

  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[31:6] == ST_INIT[31:6]) && (st_q[3:0] == 4'd0));

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_evt |=> irq);
endmodule

bind dmaq_csr dmaq_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_out), .cmpl_evt(cmpl_evt),
  .clr_evt(clr_evt), .wp_wr(wp_wr), .armed_q(armed_q), .end_q(end_q),
  .wp_q(wp_q), .rp_q(rp_q), .en_q(en_q), .st_q(st_q)
);

// File: tb/sim_dmaq_csr.sv
`timescale 1ns/1ps
module sim_dmaq_csr;
  localparam int NREG = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] m_reg [NREG];
  bit          m_armed;
  bit          m_irq;

  always #5 clk = ~clk;

  dmaq_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [31:0] ptr18(input logic [31:0] d);
    return {14'd0, d[17:0]};
  endfunction

  function automatic logic [31:0] en_bits(input logic [31:0] d);
    logic [31:0] r = d;
    r[30] = 1'b0; r[20] = 1'b0; r[11:7] = 5'd0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) m_reg[i] = 32'd0;
    m_reg[9] = 32'hF800_0000;
    m_armed = 0;
    m_irq = 0;
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int i = int'(a >> 2);
    if (i >= NREG) return;
    case (i)
      5: m_reg[5] = ptr18(d);
      6: begin
        m_reg[6] = ptr18(d);
        m_reg[7] = ptr18(d);
        if (m_armed) m_armed = 0;
        else begin
          m_reg[9][5:4] = 2'b11;
          if (m_reg[8][4] || m_reg[8][5]) m_irq = 1;
        end
      end
      7: if (d == 32'hEE88_2266) m_armed = 1;
      8: m_reg[8] = en_bits(d);
      9: if (d[4] || d[5]) begin m_reg[9][5:4] = 2'b00; m_irq = 0; end
      default: m_reg[i] = d;
    endcase
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    model_write(a, d);
    check({tag, " irq"}, {31'd0, irq_out}, {31'd0, m_irq});
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    logic [31:0] exp;
    int i = int'(a >> 2);
    exp = (i < NREG) ? m_reg[i] : 32'd0;
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    for (int i = 0; i < NREG; i++) rd("R1 reset value", 12'(i * 4));

    // R7 enable masking
    wr("R7", 12'h020, 32'hFFFF_FFFF);
    rd("R7 enable mask", 12'h020);
    // R2 end pointer masking
    wr("R2", 12'h014, 32'hFFFF_FFFF);
    rd("R2 end mask", 12'h014);
    // R3 write pointer mask and mirror; R5/R6 completion raises irq
    wr("R6 raise", 12'h018, 32'h1234_5678);
    check("R6 irq high", {31'd0, irq_out}, 32'd1);
    rd("R3 wp mask", 12'h018);
    rd("R3 rp mirror", 12'h01C);
    rd("R5 status set", 12'h024);
    // R11 read data held until next read
    @(negedge clk);
    check("R11 rdata hold", bus_rdata, 32'hF800_0030);
    // R9 enable writes do not move irq
    wr("R9 enable off", 12'h020, 32'd0);
    check("R9 irq held", {31'd0, irq_out}, 32'd1);
    // R8 status write without bits 4/5 has no effect
    wr("R8 no clear", 12'h024, 32'hFFFF_FFCF);
    rd("R8 status unchanged", 12'h024);
    // R8 clear via bit 5
    wr("R8 clear", 12'h024, 32'h0000_0020);
    check("R8 irq low", {31'd0, irq_out}, 32'd0);
    rd("R8 status cleared", 12'h024);
    // R9 enabling alone does not raise
    wr("R9 enable on", 12'h020, 32'h0000_0010);
    check("R9 no raise", {31'd0, irq_out}, 32'd0);
    // R4 non-key write ignored, key write leaves rp
    wr("R4 junk", 12'h01C, 32'h0000_1111);
    rd("R4 rp unchanged", 12'h01C);
    wr("R4 key", 12'h01C, 32'hEE88_2266);
    rd("R4 rp after key", 12'h01C);
    // R5 one-shot swallows exactly one completion
    wr("R5 swallowed", 12'h018, 32'h0000_0100);
    check("R5 irq stays low", {31'd0, irq_out}, 32'd0);
    rd("R5 status untouched", 12'h024);
    rd("R5 rp still moves", 12'h01C);
    wr("R5 next completes", 12'h018, 32'h0000_0200);
    check("R5 irq after one-shot", {31'd0, irq_out}, 32'd1);
    wr("R8 clear bit4", 12'h024, 32'h0000_0010);
    // R6 no irq when enables off
    wr("R6 en off", 12'h020, 32'h0000_0000);
    wr("R6 quiet", 12'h018, 32'h0000_0300);
    check("R6 irq not raised", {31'd0, irq_out}, 32'd0);
    rd("R6 status still set", 12'h024);
    // R10 plain storage and out-of-range
    wr("R10 base", 12'h010, 32'hCAFE_0001);
    wr("R10 low", 12'h000, 32'h1357_9BDF);
    wr("R10 top", 12'h07C, 32'hA5A5_5A5A);
    wr("R10 beyond", 12'h080, 32'hDEAD_BEEF);
    wr("R10 far", 12'hFFC, 32'hDEAD_BEEF);
    rd("R10 base read", 12'h010);
    rd("R10 low read", 12'h000);
    rd("R10 top read", 12'h07C);
    rd("R10 beyond reads zero", 12'h080);
    rd("R10 far reads zero", 12'hFFC);
    rd("R10 alias check", 12'h000);

    // Random mixed traffic against the model (R2..R10)
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1:    a = 12'h018;
        2:       a = 12'h01C;
        3:       a = 12'h020;
        4:       a = 12'h024;
        5:       a = 12'h014;
        6:       a = 12'(($urandom_range(0, NREG - 1)) * 4);
        7:       a = 12'($urandom_range(32'h080, 32'hFFF));
        default: a = 12'(($urandom_range(4, 9)) * 4);
      endcase
      d = $urandom;
      if (a == 12'h01C && $urandom_range(0, 1) == 1) d = 32'hEE88_2266;
      if (a == 12'h024 && $urandom_range(0, 2) == 0) d = d & 32'hFFFF_FFCF;
      if ($urandom_range(0, 2) == 0) rd("R10 random read", a);
      else                           wr("R6 random write", a, d);
    end
    for (int i = 4; i < 10; i++) rd("R3 final state", 12'(i * 4));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule